// File: doc/BRIEF.md
# Split-Microinstruction Control Sequencer

This block is the control front end of a microcoded 8-bit processor. Its four stages are fetch, decode, execute and writeback. At the start of every instruction, fetch takes an opcode from the opcode data bus into the instruction register. After that it reads one microinstruction per cycle from a microcode ROM. The ROM address is the instruction register concatenated with a step counter. Each word goes into the microinstruction register. Decode turns whatever the decode slot holds (an opcode or a microinstruction) into a control word. The execute stage and the writeback stage then present that word one cycle apart.

Each microinstruction is split in two. One part names the ALU operation that finishes the current operation. The other part names the operand sources for the following operation. Together with two recirculation flags and a destination, this one word covers both decode and execute. Because of that, the opcode that starts a new instruction takes the fetch slot directly and no bubble enters the pipeline. An opcode fetch works as an unconditional branch into that opcode's microcode. After reset, the first fetch produces the break opcode 0x00 and does not read the bus.

Top module: `usplit_seq`

## Requirements
- R1: While rstN is low, exValid and wbValid are 0, romAddr is 0, and every execute and writeback field is 0.
- R2: The first opcode fetch after reset loads 0x00 into the instruction register, whatever opBusData carries. Later opcode fetches load opBusData.
- R3: romAddr is {instruction register, 3-bit step}. The step is 0 in the cycle after an opcode fetch and rises by one on every microinstruction fetch.
- R4: A microinstruction word with bit 15 set makes the next cycle an opcode fetch.
- R5: A microinstruction fetched at step 7 makes the next cycle an opcode fetch even when bit 15 is clear.
- R6: Two edges after an opcode fetch, the execute outputs show exFromOp=1, exAluOp=0, exSrcA=opcode[2:0], exSrcB=opcode[5:3], both recirculation flags 0, and an internal destination of 0.
- R7: Two edges after a microinstruction fetch, the execute outputs show that word's fields with exFromOp=0. The fields are exAluOp=bits 14:12, exSrcA=bits 11:9, exSrcB=bits 8:6, exRecircR=bit 5, exRecircC=bit 4, and destination=bits 3:0.
- R8: wbValid and wbDest equal the execute valid flag and the execute destination of the previous cycle.
- R9: Once exValid rises it stays 1 until reset. An opcode with K microinstructions (K at most 8) occupies exactly K+1 execute cycles, so consecutive opcodes run with no idle cycle between them.
- R10: romData is ignored in opcode-fetch cycles, including a word with bit 15 set. opBusData is ignored in microinstruction-fetch cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opBusData | input | 8 | Opcode read from the data bus |
| romAddr | output | 11 | Microcode ROM address {opcode, step} |
| romData | input | 16 | Microinstruction word returned by the ROM |
| exValid | output | 1 | Execute-stage control word is valid |
| exFromOp | output | 1 | Execute word came from opcode decode |
| exAluOp | output | 3 | ALU operation for the current operation |
| exSrcA | output | 3 | Operand A source for the next operation |
| exSrcB | output | 3 | Operand B source for the next operation |
| exRecircR | output | 1 | Feed the ALU result back into the inputs |
| exRecircC | output | 1 | Feed the ALU carry back into the inputs |
| wbValid | output | 1 | Writeback-stage word is valid |
| wbDest | output | 4 | Writeback destination register select |

## Verification
The hardest situation to create from the ports is an opcode whose microcode never sets the end bit. In that case the sequencer must stop at step 7 on its own. The stimulus also has to show, at the same moment, that a junk ROM word (with the end bit set) presented during an opcode fetch changes nothing. The bench ROM gives opcode 0x3F a nine-step program with the end bit on the ninth step, so the forced stop at step 7 is the only way out. The opcode stream sends 0x3F twice, and every opcode-fetch cycle puts 0xFFFF on romData. A reset in the middle of the run, with a non-zero opcode held on the bus, covers the forced break fetch a second time.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
  typedef struct packed {
    logic takeOp;
    logic useBrk;
    logic takeMicro;
  } seqStrobeT;
endpackage

// File: rtl/usplit_ctrl.sv
module usplit_ctrl
  import usplit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      romEnd,
  input  logic      stepAtMax,
  output seqStrobeT strb
);
  logic opFetch;
  logic brkPend;

  always_comb begin
    strb.takeOp    = opFetch;
    strb.useBrk    = opFetch & brkPend;
    strb.takeMicro = ~opFetch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opFetch <= 1'b1;
      brkPend <= 1'b1;
    end else begin
      opFetch <= strb.takeMicro & (romEnd | stepAtMax);
      if (opFetch) brkPend <= 1'b0;
    end
  end
endmodule

// File: rtl/usplit_decode.sv
module usplit_decode #(
  parameter int OPW    = 8,
  parameter int UW     = 16,
  parameter int ALUOPW = 3,
  parameter int SRCW   = 3,
  parameter int DESTW  = 4
) (
  input  logic              isOp,
  input  logic [OPW-1:0]    ir,
  input  logic [UW-1:0]     mir,
  output logic [ALUOPW-1:0] aluOp,
  output logic [SRCW-1:0]   srcA,
  output logic [SRCW-1:0]   srcB,
  output logic              recircR,
  output logic              recircC,
  output logic [DESTW-1:0]  dest
);
  localparam int RC_BIT  = DESTW;
  localparam int RR_BIT  = DESTW + 1;
  localparam int SRCB_LO = DESTW + 2;
  localparam int SRCA_LO = SRCB_LO + SRCW;
  localparam int ALU_LO  = SRCA_LO + SRCW;

  logic [SRCW-1:0] opSrcA;
  logic [SRCW-1:0] opSrcB;

  generate
    if (OPW >= 2 * SRCW) begin : g_wideOp
      assign opSrcA = ir[SRCW-1:0];
      assign opSrcB = ir[2*SRCW-1:SRCW];
    end else begin : g_narrowOp
      logic [2*SRCW-1:0] irExt;
      assign irExt  = {{(2*SRCW-OPW){1'b0}}, ir};
      assign opSrcA = irExt[SRCW-1:0];
      assign opSrcB = irExt[2*SRCW-1:SRCW];
    end
  endgenerate

  always_comb begin
    if (isOp) begin
      aluOp   = '0;
      srcA    = opSrcA;
      srcB    = opSrcB;
      recircR = 1'b0;
      recircC = 1'b0;
      dest    = '0;
    end else begin
      aluOp   = mir[ALU_LO +: ALUOPW];
      srcA    = mir[SRCA_LO +: SRCW];
      srcB    = mir[SRCB_LO +: SRCW];
      recircR = mir[RR_BIT];
      recircC = mir[RC_BIT];
      dest    = mir[DESTW-1:0];
    end
  end
endmodule

// File: rtl/usplit_path.sv
module usplit_path
  import usplit_pkg::*;
#(
  parameter int OPW    = 8,
  parameter int STEPW  = 3,
  parameter int UW     = 16,
  parameter int ALUOPW = 3,
  parameter int SRCW   = 3,
  parameter int DESTW  = 4,
  parameter logic [OPW-1:0] BRK_OP = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            strb,
  input  logic [OPW-1:0]       opBusData,
  input  logic [UW-1:0]        romData,
  output logic [OPW+STEPW-1:0] romAddr,
  output logic                 romEnd,
  output logic                 stepAtMax,
  output logic                 exValid,
  output logic                 exFromOp,
  output logic [ALUOPW-1:0]    exAluOp,
  output logic [SRCW-1:0]      exSrcA,
  output logic [SRCW-1:0]      exSrcB,
  output logic                 exRecircR,
  output logic                 exRecircC,
  output logic [DESTW-1:0]     exDest,
  output logic                 wbValid,
  output logic [DESTW-1:0]     wbDest
);
  logic [OPW-1:0]   ir;
  logic [STEPW-1:0] step;
  logic [UW-1:0]    mir;
  logic             decIsOp;
  logic             decValid;

  logic [ALUOPW-1:0] dAluOp;
  logic [SRCW-1:0]   dSrcA;
  logic [SRCW-1:0]   dSrcB;
  logic              dRecircR;
  logic              dRecircC;
  logic [DESTW-1:0]  dDest;

  assign romAddr   = {ir, step};
  assign romEnd    = romData[UW-1];
  assign stepAtMax = &step;

  // fetch stage: opcode into ir, or microinstruction into mir
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ir       <= '0;
      step     <= '0;
      mir      <= '0;
      decIsOp  <= 1'b0;
      decValid <= 1'b0;
    end else begin
      decValid <= 1'b1;
      if (strb.takeOp) begin
        ir      <= strb.useBrk ? BRK_OP : opBusData;
        step    <= '0;
        decIsOp <= 1'b1;
      end else begin
        mir     <= romData;
        step    <= step + 1'b1;
        decIsOp <= 1'b0;
      end
    end
  end

  usplit_decode #(
    .OPW(OPW), .UW(UW), .ALUOPW(ALUOPW), .SRCW(SRCW), .DESTW(DESTW)
  ) decI (
    .isOp   (decIsOp),
    .ir     (ir),
    .mir    (mir),
    .aluOp  (dAluOp),
    .srcA   (dSrcA),
    .srcB   (dSrcB),
    .recircR(dRecircR),
    .recircC(dRecircC),
    .dest   (dDest)
  );

  // execute and writeback stage registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exValid   <= 1'b0;
      exFromOp  <= 1'b0;
      exAluOp   <= '0;
      exSrcA    <= '0;
      exSrcB    <= '0;
      exRecircR <= 1'b0;
      exRecircC <= 1'b0;
      exDest    <= '0;
      wbValid   <= 1'b0;
      wbDest    <= '0;
    end else begin
      exValid   <= decValid;
      exFromOp  <= decIsOp;
      exAluOp   <= dAluOp;
      exSrcA    <= dSrcA;
      exSrcB    <= dSrcB;
      exRecircR <= dRecircR;
      exRecircC <= dRecircC;
      exDest    <= dDest;
      wbValid   <= exValid;
      wbDest    <= exDest;
    end
  end
endmodule

// File: rtl/usplit_seq.sv
module usplit_seq
  import usplit_pkg::*;
#(
  parameter int OPW    = 8,
  parameter int STEPW  = 3,
  parameter int ALUOPW = 3,
  parameter int SRCW   = 3,
  parameter int DESTW  = 4,
  parameter logic [OPW-1:0] BRK_OP = '0,
  localparam int UW = 1 + ALUOPW + 2 * SRCW + 2 + DESTW,
  localparam int AW = OPW + STEPW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPW-1:0]    opBusData,
  output logic [AW-1:0]     romAddr,
  input  logic [UW-1:0]     romData,
  output logic              exValid,
  output logic              exFromOp,
  output logic [ALUOPW-1:0] exAluOp,
  output logic [SRCW-1:0]   exSrcA,
  output logic [SRCW-1:0]   exSrcB,
  output logic              exRecircR,
  output logic              exRecircC,
  output logic              wbValid,
  output logic [DESTW-1:0]  wbDest
);
  seqStrobeT        strb;
  logic             romEnd;
  logic             stepAtMax;
  logic [DESTW-1:0] exDest;

  usplit_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .romEnd   (romEnd),
    .stepAtMax(stepAtMax),
    .strb     (strb)
  );

  usplit_path #(
    .OPW(OPW), .STEPW(STEPW), .UW(UW), .ALUOPW(ALUOPW),
    .SRCW(SRCW), .DESTW(DESTW), .BRK_OP(BRK_OP)
  ) pathI (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opBusData(opBusData),
    .romData  (romData),
    .romAddr  (romAddr),
    .romEnd   (romEnd),
    .stepAtMax(stepAtMax),
    .exValid  (exValid),
    .exFromOp (exFromOp),
    .exAluOp  (exAluOp),
    .exSrcA   (exSrcA),
    .exSrcB   (exSrcB),
    .exRecircR(exRecircR),
    .exRecircC(exRecircC),
    .exDest   (exDest),
    .wbValid  (wbValid),
    .wbDest   (wbDest)
  );
endmodule

// File: rtl/usplit_seq_chk.sv
module usplit_seq_chk #(
  parameter int AW     = 11,
  parameter int STEPW  = 3,
  parameter int UW     = 16,
  parameter int ALUOPW = 3,
  parameter int DESTW  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              takeOp,
  input logic [AW-1:0]     romAddr,
  input logic [UW-1:0]     romData,
  input logic              exValid,
  input logic              exFromOp,
  input logic [ALUOPW-1:0] exAluOp,
  input logic              exRecircR,
  input logic              exRecircC,
  input logic [DESTW-1:0]  exDest,
  input logic              wbValid,
  input logic [DESTW-1:0]  wbDest
);
  // R9
  exec_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    exValid |=> exValid);

  // R9
  no_double_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeOp |=> !takeOp);

  // R8
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    exValid |=> (wbValid && wbDest == $past(exDest)));

  // R6
  opword_neutral_chk: assert property (@(posedge clk) disable iff (!rstN)
    exFromOp |-> (exAluOp == '0 && !exRecircR && !exRecircC && exDest == '0));

  // R4
  end_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!takeOp && romData[UW-1]) |=> takeOp);

  // R5
  step_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!takeOp && (&romAddr[STEPW-1:0])) |=> takeOp);

  // R3
  step_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeOp |=> (romAddr[STEPW-1:0] == '0));
endmodule

bind usplit_seq usplit_seq_chk #(
  .AW(AW), .STEPW(STEPW), .UW(UW), .ALUOPW(ALUOPW), .DESTW(DESTW)
) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .takeOp   (strb.takeOp),
  .romAddr  (romAddr),
  .romData  (romData),
  .exValid  (exValid),
  .exFromOp (exFromOp),
  .exAluOp  (exAluOp),
  .exRecircR(exRecircR),
  .exRecircC(exRecircC),
  .exDest   (exDest),
  .wbValid  (wbValid),
  .wbDest   (wbDest)
);

// File: tb/usplit_seq_tb.sv
`timescale 1ns/1ps
module usplit_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  opBusData = 8'h00;
  logic [10:0] romAddr;
  logic [15:0] romData = 16'h0000;
  logic        exValid, exFromOp, exRecircR, exRecircC, wbValid;
  logic [2:0]  exAluOp, exSrcA, exSrcB;
  logic [3:0]  wbDest;

  always #2 clk = ~clk;

  usplit_seq dut_i (
    .clk(clk), .rstN(rstN), .opBusData(opBusData), .romAddr(romAddr),
    .romData(romData), .exValid(exValid), .exFromOp(exFromOp),
    .exAluOp(exAluOp), .exSrcA(exSrcA), .exSrcB(exSrcB),
    .exRecircR(exRecircR), .exRecircC(exRecircC),
    .wbValid(wbValid), .wbDest(wbDest)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  bit       mOpFetch, mBrk, mDecIsOp, mDecValid;
  bit [7:0] mIr;
  int       mStep;
  bit [15:0] mMir;
  bit       eValid, eFromOp, eRR, eRC, wValid;
  bit [2:0] eAlu, eSA, eSB;
  bit [3:0] eDest, wDest;
  bit [7:0] taken[$];
  int       cyc = 0;
  int       lastOpCyc;
  int       lastLen;
  bit       haveLast;
  int       seqIdx = 0;
  bit [7:0] opSeq[10] = '{8'h12, 8'h3F, 8'h07, 8'hA4, 8'h5B,
                          8'h01, 8'h3F, 8'hC8, 8'hFF, 8'h46};

  function automatic int progLen(bit [7:0] op);
    return (op == 8'h3F) ? 9 : (op % 5) + 1;
  endfunction

  function automatic bit [15:0] romWord(bit [7:0] op, int st);
    bit [7:0] a, s, b, d;
    a = op + 8'(st);
    s = op * 3 + 8'(st);
    b = op ^ 8'(st);
    d = op + 8'(st * 3);
    return {(st == progLen(op) - 1), a[2:0], s[2:0], b[2:0],
            1'(st & 1), op[0] ^ 1'((st >> 1) & 1), d[3:0]};
  endfunction

  task automatic modelReset();
    mOpFetch = 1; mBrk = 1; mDecIsOp = 0; mDecValid = 0;
    mIr = 0; mStep = 0; mMir = 0;
    eValid = 0; eFromOp = 0; eRR = 0; eRC = 0; eAlu = 0; eSA = 0; eSB = 0;
    eDest = 0; wValid = 0; wDest = 0;
    taken.delete(); haveLast = 0;
  endtask

  task automatic note(string req, string what, int act, int exp, inout bit bad);
    $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    bad = 1;
  endtask

  task automatic compare();
    bit bad = 0;
    compared++;
    if (romAddr !== {mIr, 3'(mStep)}) note("R3", "romAddr", romAddr, {mIr, 3'(mStep)}, bad);
    if (exValid !== eValid) note("R1/R9 exValid", "", exValid, eValid, bad);
    if (exFromOp !== eFromOp) note("R6/R7 exFromOp", "", exFromOp, eFromOp, bad);
    if (exAluOp !== eAlu) note("R7 exAluOp", "", exAluOp, eAlu, bad);
    if (exSrcA !== eSA) note("R6/R7 exSrcA", "", exSrcA, eSA, bad);
    if (exSrcB !== eSB) note("R6/R7 exSrcB", "", exSrcB, eSB, bad);
    if (exRecircR !== eRR) note("R7 exRecircR", "", exRecircR, eRR, bad);
    if (exRecircC !== eRC) note("R7 exRecircC", "", exRecircC, eRC, bad);
    if (wbValid !== wValid) note("R8 wbValid", "", wbValid, wValid, bad);
    if (wbDest !== wDest) note("R8 wbDest", "", wbDest, wDest, bad);
    // R9: gap between opcode words equals program length plus one
    if (exValid === 1'b1 && exFromOp === 1'b1) begin
      if (haveLast) begin
        compared++;
        if (cyc - lastOpCyc != lastLen + 1) begin
          $display("FAIL R9 opcode spacing cycle %0d: actual %0d expected %0d",
                   cyc, cyc - lastOpCyc, lastLen + 1);
          mismatched++;
        end
      end
      if (taken.size() > 0) begin
        bit [7:0] op = taken.pop_front();
        lastLen = (progLen(op) > 8) ? 8 : progLen(op);
      end
      haveLast = 1;
      lastOpCyc = cyc;
    end
    if (bad) mismatched++;
  endtask

  task automatic cycle(bit rst);
    bit [7:0] busNow;
    @(negedge clk);
    compare();
    cyc++;
    rstN = !rst;
    busNow = opSeq[seqIdx % 10];
    opBusData = busNow;
    // R10: junk word with end bit set during opcode fetch
    romData = mOpFetch ? 16'hFFFF : romWord(mIr, mStep);
    if (rst) begin
      modelReset();
    end else begin
      wValid = eValid; wDest = eDest;
      eValid = mDecValid; eFromOp = mDecIsOp;
      if (mDecIsOp) begin
        eAlu = 0; eSA = mIr[2:0]; eSB = mIr[5:3]; eRR = 0; eRC = 0; eDest = 0;
      end else begin
        eAlu = mMir[14:12]; eSA = mMir[11:9]; eSB = mMir[8:6];
        eRR = mMir[5]; eRC = mMir[4]; eDest = mMir[3:0];
      end
      mDecValid = 1;
      if (mOpFetch) begin
        // R2: break opcode on first fetch
        mIr = mBrk ? 8'h00 : busNow;
        if (!mBrk) seqIdx++;
        taken.push_back(mIr);
        mBrk = 0; mStep = 0; mDecIsOp = 1; mOpFetch = 0;
      end else begin
        mMir = romData;
        mOpFetch = romData[15] || (mStep == 7);
        mStep = (mStep + 1) % 8;
        mDecIsOp = 0;
      end
    end
  endtask

  initial begin
    modelReset();
    repeat (4) cycle(1);       // R1 reset state
    repeat (150) cycle(0);
    repeat (3) cycle(1);       // R2 mid-run reset with non-zero bus
    repeat (70) cycle(0);
    @(negedge clk);
    compare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule